// File: doc/BRIEF.md
# Synchronous SRAM Cycle Controller with Sleep

This block sits in front of a small pipelined synchronous SRAM with byte-lane write masks. On each rising clock edge it samples these inputs:

- the combined chip enable
- the load/advance control
- the write control
- the per-lane write selects
- the clock enable

From them it decides what kind of cycle the edge was: deselect, read, dummy read or write, each as a begin or a continue. It generates burst addresses in linear or interleaved order and drives the data-bus output enable. It performs the storage access on an internal byte-lane array.

The sleep input is asynchronous. It is brought in through a two-stage synchronizer, so entering and leaving sleep each take two edges. Stored data is kept while asleep. Accesses presented while asleep are dropped. After waking, a recovery window rejects any edge with the chip enable high: that edge is treated as a deselect and flagged on `err_o`. The output enable acts combinationally. It is masked for write, deselect and sleep cycles.

Cycle codes on `cycle_o`:

| Code | Cycle |
|------|-------|
| 0 | deselect |
| 1 | deselect continue |
| 2 | read |
| 3 | read continue |
| 4 | write |
| 5 | write continue |
| 6 | sleep |
| 7 | dummy read |
| 8 | dummy read continue |

Top module: `sram_sleep_ctl`

## Requirements
- R1: While reset is held and after its release, `cycle_o` is 0 and `dq_oe_o` is 0, whatever the value of `oe_i`.
- R2: An edge with `adv_i`=0 and `ce_i`=0 is a deselect (code 0). An edge with `adv_i`=1 that follows a deselect is a deselect continue (code 1), whatever `ce_i` and `wr_i` are.
- R3: An edge with `adv_i`=0, `ce_i`=1 and `wr_i`=0 begins a read at `addr_i` (code 2). `rdata_o` is loaded at that edge. Each following `adv_i`=1 edge is a read continue (code 3) at the next burst address.
- R4: The burst address keeps the upper address bits of the starting address and changes only the two low bits. With `lin_order_i`=1, beat n uses (start + n) mod 4 in the low bits. With `lin_order_i`=0, it uses start XOR n.
- R5: When `oe_i`=0, a read reports code 7 (begin) or 8 (continue) and `dq_oe_o` is 0. `oe_i` reaches `dq_oe_o` without passing through a clock edge.
- R6: An edge with `adv_i`=0, `ce_i`=1 and `wr_i`=1 is a write (code 4), and `adv_i`=1 edges after it are write continues (code 5). `dq_oe_o` stays 0 during writes even with `oe_i`=1.
- R7: On each write beat, only byte lane i (bits 8i+7:8i) with `bw_i[i]`=1 is written, using that beat's own `bw_i`.
- R8: An edge with `clk_en_i`=0 changes neither `cycle_o`, `rdata_o` nor the burst position.
- R9: `sleep_o` rises at the second edge after `sleep_i` goes high, and falls at the second edge after it goes low. An edge that finds `sleep_o` high reports code 6, performs no access and leaves `dq_oe_o` at 0.
- R10: Stored data is unchanged across sleep, including when a write is presented while asleep.
- R11: For REC_CYCLES edges after the edge at which `sleep_o` falls, an edge with `ce_i`=1 produces an `err_o` pulse and is treated as a deselect (code 0 or 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Asynchronous sleep request |
| clk_en_i | input | 1 | Clock enable; low makes the edge a wait state |
| ce_i | input | 1 | All chip enables active |
| adv_i | input | 1 | 0 = load new address, 1 = advance burst |
| wr_i | input | 1 | 1 = write, 0 = read (sampled on load) |
| bw_i | input | LANES | Byte-lane write selects |
| oe_i | input | 1 | Asynchronous output enable |
| lin_order_i | input | 1 | 1 = linear burst, 0 = interleaved |
| addr_i | input | AW | External address |
| wdata_i | input | LANES*LW | Write data |
| rdata_o | output | LANES*LW | Registered read data |
| dq_oe_o | output | 1 | Data-bus drive enable |
| cycle_o | output | 4 | Current cycle code |
| sleep_o | output | 1 | Synchronized sleep state |
| err_o | output | 1 | Access attempted in recovery window |

## Verification
The hardest state to reach is the recovery window. It exists only for a few edges after `sleep_o` falls, and `sleep_o` itself lags the asynchronous input by two edges. The bench raises `sleep_i` next to a deselect and counts edges through entry. While asleep it presents a write, to show that the write is dropped. It then lowers `sleep_i` and counts to the falling edge of `sleep_o`. It presents an access on the very next edge, and a read after the window shows that the earlier stored word survived.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [3:0] {
    CYC_DESEL      = 4'd0,
    CYC_DESEL_CONT = 4'd1,
    CYC_READ       = 4'd2,
    CYC_READ_CONT  = 4'd3,
    CYC_WRITE      = 4'd4,
    CYC_WRITE_CONT = 4'd5,
    CYC_SLEEP      = 4'd6,
    CYC_DUMMY      = 4'd7,
    CYC_DUMMY_CONT = 4'd8
  } cyc_e;

  typedef enum logic [1:0] {
    K_DESEL = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } kind_e;
endpackage

// File: rtl/sram_sleep_sync.sv
module sram_sleep_sync #(
  parameter int REC_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic asleep_o,
  output logic lockout_o
);
  localparam int RW = $clog2(REC_CYCLES + 1) < 1 ? 1 : $clog2(REC_CYCLES + 1);
  localparam logic [RW-1:0] REC_LOAD = RW'(REC_CYCLES);

  logic s1_q, s2_q;
  logic [RW-1:0] rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      rec_q <= '0;
    end else begin
      s1_q <= sleep_i;
      s2_q <= s1_q;
      if (s2_q && !s1_q)    rec_q <= REC_LOAD;
      else if (rec_q != '0) rec_q <= rec_q - 1'b1;
    end
  end

  assign asleep_o  = s2_q;
  assign lockout_o = (rec_q != '0);
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
  parameter int AW = 4,
  parameter int BB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          lin_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_addr_o
);
  logic [AW-1:0] base_q;
  logic [BB-1:0] cnt_q, cnt_nxt, lo;

  assign cnt_nxt = cnt_q + 1'b1;
  assign lo = lin_i ? (base_q[BB-1:0] + cnt_nxt) : (base_q[BB-1:0] ^ cnt_nxt);

  always_comb begin
    if (load_i) eff_addr_o = addr_i;
    else        eff_addr_o = {base_q[AW-1:BB], lo};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sram_byte_store.sv
module sram_byte_store #(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [LANES-1:0]    be_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [LANES*LW-1:0] wdata_i,
  output logic [LANES*LW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) mem[addr_i] <= wdata_i[g*LW +: LW];
    end
    assign rdata_o[g*LW +: LW] = mem[addr_i];
  end
endmodule

// File: rtl/sram_sleep_ctl.sv
module sram_sleep_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW         = 4,
  parameter int LANES      = 4,
  parameter int LW         = 8,
  parameter int REC_CYCLES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_i,
  input  logic                clk_en_i,
  input  logic                ce_i,
  input  logic                adv_i,
  input  logic                wr_i,
  input  logic [LANES-1:0]    bw_i,
  input  logic                oe_i,
  input  logic                lin_order_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [LANES*LW-1:0] wdata_i,
  output logic [LANES*LW-1:0] rdata_o,
  output logic                dq_oe_o,
  output logic [3:0]          cycle_o,
  output logic                sleep_o,
  output logic                err_o
);
  localparam int DW = LANES * LW;

  logic asleep, lockout;
  logic do_load, do_step, mem_we, rd_en, err_nxt;
  cyc_e  cyc_q, cyc_nxt;
  kind_e kind_q, kind_nxt;
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] mem_rdata, rdata_q;
  logic err_q;

  sram_sleep_sync #(.REC_CYCLES(REC_CYCLES)) u_sleep (
    .clk_i, .rst_ni, .sleep_i,
    .asleep_o (asleep),
    .lockout_o(lockout)
  );

  always_comb begin
    cyc_nxt  = cyc_q;
    kind_nxt = kind_q;
    do_load  = 1'b0;
    do_step  = 1'b0;
    err_nxt  = 1'b0;
    if (asleep) begin
      cyc_nxt  = CYC_SLEEP;
      kind_nxt = K_DESEL;
    end else if (lockout) begin
      err_nxt  = ce_i;
      kind_nxt = K_DESEL;
      cyc_nxt  = adv_i ? CYC_DESEL_CONT : CYC_DESEL;
    end else if (clk_en_i) begin
      if (!adv_i) begin
        do_load = 1'b1;
        if (ce_i) begin
          kind_nxt = wr_i ? K_WRITE : K_READ;
          cyc_nxt  = wr_i ? CYC_WRITE : CYC_READ;
        end else begin
          kind_nxt = K_DESEL;
          cyc_nxt  = CYC_DESEL;
        end
      end else begin
        do_step = 1'b1;
        unique case (kind_q)
          K_READ:  cyc_nxt = CYC_READ_CONT;
          K_WRITE: cyc_nxt = CYC_WRITE_CONT;
          default: cyc_nxt = CYC_DESEL_CONT;
        endcase
      end
    end
  end

  assign mem_we = (do_load | do_step) && (kind_nxt == K_WRITE);
  assign rd_en  = (do_load | do_step) && (kind_nxt == K_READ);

  sram_burst_addr #(.AW(AW), .BB(2)) u_addr (
    .clk_i, .rst_ni,
    .load_i    (do_load),
    .step_i    (do_step),
    .lin_i     (lin_order_i),
    .addr_i    (addr_i),
    .eff_addr_o(eff_addr)
  );

  sram_byte_store #(.AW(AW), .LANES(LANES), .LW(LW)) u_store (
    .clk_i,
    .we_i   (mem_we),
    .be_i   (bw_i),
    .addr_i (eff_addr),
    .wdata_i(wdata_i),
    .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= CYC_DESEL;
      kind_q  <= K_DESEL;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      cyc_q  <= cyc_nxt;
      kind_q <= kind_nxt;
      err_q  <= err_nxt;
      if (rd_en) rdata_q <= mem_rdata;
    end
  end

  // oe_i is asynchronous: it gates only the registered read classification
  always_comb begin
    cycle_o = cyc_q;
    if (!oe_i && cyc_q == CYC_READ)      cycle_o = CYC_DUMMY;
    if (!oe_i && cyc_q == CYC_READ_CONT) cycle_o = CYC_DUMMY_CONT;
  end

  assign dq_oe_o = oe_i && (cyc_q == CYC_READ || cyc_q == CYC_READ_CONT);
  assign rdata_o = rdata_q;
  assign sleep_o = asleep;
  assign err_o   = err_q;
endmodule

// File: rtl/sram_sleep_ctl_chk.sv
module sram_sleep_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_i,
  input logic       oe_i,
  input logic       dq_oe_o,
  input logic [3:0] cycle_o,
  input logic       sleep_o,
  input logic       err_o
);
  // R5
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_i);

  // R6
  wr_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o == 4'd4 || cycle_o == 4'd5) |-> !dq_oe_o);

  // R9
  sleep_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o == 4'd6) |-> !dq_oe_o);

  // R9
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(sleep_i));

  // R11
  rec_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cycle_o == 4'd0 || cycle_o == 4'd1));
endmodule

bind sram_sleep_ctl sram_sleep_ctl_chk u_chk (.*);

// File: tb/sram_sleep_ctl_bench.sv
module sram_sleep_ctl_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_i = 1'b0, clk_en_i = 1'b1, ce_i = 1'b0, adv_i = 1'b0, wr_i = 1'b0;
  logic [3:0] bw_i = '0;
  logic oe_i = 1'b1, lin_order_i = 1'b1;
  logic [3:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic dq_oe_o, sleep_o, err_o;
  logic [3:0] cycle_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_sleep_ctl u_sram_sleep_ctl (
    .clk_i(clk), .rst_ni, .sleep_i, .clk_en_i, .ce_i, .adv_i, .wr_i, .bw_i,
    .oe_i, .lin_order_i, .addr_i, .wdata_i, .rdata_o, .dq_oe_o, .cycle_o,
    .sleep_o, .err_o
  );

  typedef struct packed {
    logic cen, adv, ce, wr;
    logic [3:0] bw;
    logic oe, lin;
    logic [3:0] addr;
    logic [31:0] wd;
    logic [3:0] cyc;
    logic doe, chk;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,4'd0,32'h0,       4'd0,1'b0,1'b0,32'h0},        // R2 deselect
    '{1'b1,1'b1,1'b1,1'b1,4'h0,1'b1,1'b1,4'd0,32'h0,       4'd1,1'b0,1'b0,32'h0},        // R2 continue
    '{1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b1,4'd4,32'hA0A0A0A0,4'd4,1'b0,1'b0,32'h0},        // R6 write begin
    '{1'b1,1'b1,1'b0,1'b0,4'hF,1'b1,1'b1,4'd0,32'hB1B1B1B1,4'd5,1'b0,1'b0,32'h0},        // R6
    '{1'b1,1'b1,1'b0,1'b0,4'hF,1'b1,1'b1,4'd0,32'hC2C2C2C2,4'd5,1'b0,1'b0,32'h0},
    '{1'b1,1'b1,1'b0,1'b0,4'hF,1'b1,1'b1,4'd0,32'hD3D3D3D3,4'd5,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,1'b1,1'b1,4'h5,1'b0,1'b1,4'd6,32'hFFFFFFFF,4'd4,1'b0,1'b0,32'h0},        // R7 lanes 0,2
    '{1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,1'b1,4'd0,32'h0,       4'd5,1'b0,1'b0,32'h0},        // R7 no lanes
    '{1'b1,1'b0,1'b1,1'b0,4'h0,1'b1,1'b1,4'd5,32'h0,       4'd2,1'b1,1'b1,32'hB1B1B1B1}, // R3
    '{1'b1,1'b1,1'b0,1'b0,4'h0,1'b1,1'b1,4'd0,32'h0,       4'd3,1'b1,1'b1,32'hC2FFC2FF}, // R3 R7
    '{1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,1'b1,4'd0,32'h0,       4'd3,1'b1,1'b1,32'hC2FFC2FF}, // R8 stall
    '{1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,1'b1,4'd0,32'h0,       4'd8,1'b0,1'b1,32'hD3D3D3D3}, // R5
    '{1'b1,1'b1,1'b0,1'b0,4'h0,1'b1,1'b1,4'd0,32'h0,       4'd3,1'b1,1'b1,32'hA0A0A0A0}, // R4 wrap
    '{1'b1,1'b0,1'b1,1'b0,4'h0,1'b0,1'b0,4'd6,32'h0,       4'd7,1'b0,1'b1,32'hC2FFC2FF}, // R5 dummy
    '{1'b1,1'b1,1'b0,1'b0,4'h0,1'b1,1'b0,4'd0,32'h0,       4'd3,1'b1,1'b1,32'hD3D3D3D3}, // R4 xor
    '{1'b1,1'b1,1'b0,1'b0,4'h0,1'b1,1'b0,4'd0,32'h0,       4'd3,1'b1,1'b1,32'hA0A0A0A0},
    '{1'b1,1'b1,1'b0,1'b0,4'h0,1'b1,1'b0,4'd0,32'h0,       4'd3,1'b1,1'b1,32'hB1B1B1B1},
    '{1'b1,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,4'd0,32'h0,       4'd0,1'b0,1'b0,32'h0}         // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic cen, adv, ce, wr, input logic [3:0] bw,
                      input logic oe, lin, input logic [3:0] a, input logic [31:0] wd);
    @(negedge clk);
    clk_en_i = cen; adv_i = adv; ce_i = ce; wr_i = wr; bw_i = bw;
    oe_i = oe; lin_order_i = lin; addr_i = a; wdata_i = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset with oe high
    repeat (2) @(posedge clk);
    #1;
    check("R1 cycle in reset", 32'(cycle_o), 32'd0);
    check("R1 dq_oe in reset", 32'(dq_oe_o), 32'd0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1 cycle after reset", 32'(cycle_o), 32'd0);
    check("R1 dq_oe after reset", 32'(dq_oe_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].cen, VECS[i].adv, VECS[i].ce, VECS[i].wr, VECS[i].bw,
           VECS[i].oe, VECS[i].lin, VECS[i].addr, VECS[i].wd);
      check($sformatf("R2-vec%0d cycle", i), 32'(cycle_o), 32'(VECS[i].cyc));
      check($sformatf("R5 R6 vec%0d dq_oe", i), 32'(dq_oe_o), 32'(VECS[i].doe));
      if (VECS[i].chk) check($sformatf("R3 R4 vec%0d rdata", i), rdata_o, VECS[i].rd);
    end

    // R5 oe acts without a clock edge
    step(1,0,1,0,4'h0,1,1,4'd4,0);
    check("R3 read begin", 32'(cycle_o), 32'd2);
    @(negedge clk); oe_i = 1'b0; #1;
    check("R5 async oe drop", 32'(dq_oe_o), 32'd0);
    check("R5 async dummy code", 32'(cycle_o), 32'd7);

    // R9 sleep entry, R10 write while asleep
    step(1,0,0,0,4'h0,1,1,4'd0,0);
    sleep_i = 1'b1;
    step(1,0,0,0,4'h0,1,1,4'd0,0);
    check("R9 not asleep after 1 edge", 32'(sleep_o), 32'd0);
    step(1,0,0,0,4'h0,1,1,4'd0,0);
    check("R9 asleep after 2 edges", 32'(sleep_o), 32'd1);
    step(1,0,1,1,4'hF,1,1,4'd6,32'h0);
    check("R9 sleep code", 32'(cycle_o), 32'd6);
    check("R9 sleep tristate", 32'(dq_oe_o), 32'd0);
    sleep_i = 1'b0;
    step(1,0,0,0,4'h0,1,1,4'd0,0);
    check("R9 still asleep 1 edge after", 32'(sleep_o), 32'd1);
    step(1,0,0,0,4'h0,1,1,4'd0,0);
    check("R9 awake 2 edges after", 32'(sleep_o), 32'd0);
    // R11 recovery window
    step(1,0,1,0,4'h0,1,1,4'd6,0);
    check("R11 err in window", 32'(err_o), 32'd1);
    check("R11 deselect in window", 32'(cycle_o), 32'd0);
    check("R11 no drive in window", 32'(dq_oe_o), 32'd0);
    step(1,0,0,0,4'h0,1,1,4'd0,0);
    check("R11 no err without ce", 32'(err_o), 32'd0);
    step(1,0,1,0,4'h0,1,1,4'd6,0);
    check("R11 access after window", 32'(cycle_o), 32'd2);
    check("R11 no err after window", 32'(err_o), 32'd0);
    check("R10 data kept through sleep", rdata_o, 32'hC2FFC2FF);
    step(1,0,0,0,4'h0,1,1,4'd0,0);
    finish_run();
  end
endmodule